// File: doc/BRIEF.md
# Interrupt Context Save Sequencer

This block writes the interrupted program's context to the stack once an interrupt request has been accepted. The context is a 20-bit program counter and a 12-bit flag word. The block picks one of two 16-bit stack pointers, packs the context into four stack bytes, and stores them through a 16-bit data memory write port that has byte enables and a ready handshake. It then returns the stack pointer, lowered by four, and says which pointer it belongs to.

The number and width of the writes follow the parity of the chosen stack pointer. An even pointer takes two 16-bit word writes. An odd pointer takes four single-byte writes. The four bytes land in the same place either way. Writes run from the higher address downward.

The rest of interrupt entry stays with the surrounding core: vector fetch, priority resolution and flag clearing. The core pulses a start, waits for the done pulse, and then loads the returned value into the pointer named by the select output.

Top module: `ctx_save_seq`

## Requirements
- R1: After reset the write strobe and the done pulse are both low, and no write is pending.
- R2: When the request is a software interrupt numbered from 32 to 63 and the user-stack flag is 1, the user stack pointer is used. Every other combination uses the interrupt stack pointer. The output `sp_is_user_o` reports the choice: 1 means user.
- R3: With an even pointer S there are exactly two writes, both with byte enables `11`. The first goes to S-2 with data {flag[11:8], pc[19:16], flag[7:0]}. The second goes to S-4 with data {pc[15:8], pc[7:0]}.
- R4: With an odd pointer S there are exactly four byte writes, to S-1, S-2, S-3 and S-4 in that order. They carry {flag[11:8], pc[19:16]}, flag[7:0], pc[15:8] and pc[7:0]. An even address enables lane 0 (enables `01`, byte on data[7:0]). An odd address enables lane 1 (enables `10`, byte on data[15:8]).
- R5: While the write strobe is high and `mem_ready_i` is low, the address, data and byte enables stay unchanged into the next cycle, and the strobe stays high.
- R6: `done_o` is high for exactly one cycle, in the cycle after the last write is accepted, with the strobe low. In that cycle `new_sp_o` equals the selected pointer minus 4, modulo 2^16.
- R7: A start pulse that arrives while a save is in progress is ignored. No extra writes and no second done pulse follow from it.
- R8: In both alignments the stack bytes S-4 up to S-1, read from the lowest address upward, are PC low byte, PC middle byte, flag low byte, and {flag high nibble, PC high nibble}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Accepted-interrupt pulse; starts a save when idle |
| is_sw_int_i | input | 1 | Request comes from a software interrupt instruction |
| int_num_i | input | 8 | Software interrupt number |
| user_stack_flag_i | input | 1 | Stack select flag from the flag word (1 = user) |
| pc_i | input | 20 | Program counter to save |
| flags_i | input | 12 | Flag word to save |
| isp_i | input | 16 | Interrupt stack pointer |
| usp_i | input | 16 | User stack pointer |
| mem_addr_o | output | 16 | Byte address of the current write |
| mem_wdata_o | output | 16 | Write data |
| mem_be_o | output | 2 | Byte enables, bit 0 = data[7:0] |
| mem_we_o | output | 1 | Write strobe, held until ready |
| mem_ready_i | input | 1 | Memory accepts the write at this edge |
| done_o | output | 1 | One-cycle completion pulse |
| new_sp_o | output | 16 | Updated stack pointer, valid with done |
| sp_is_user_o | output | 1 | Updated pointer is the user pointer |

## Verification
The assertions assume that the memory side may hold `mem_ready_i` low for any number of cycles but never withdraws a write by itself. They also assume that the context inputs only have to be valid in the cycle of the start pulse, because the block latches them then. The bench drives ready from a per-scenario stall count that always runs out. It changes the program counter only after the start has been taken, or on purpose during a save to show that the latched copy is used. Scenarios cover both parities, both pointers, the edges of the software-number window, and a pointer that wraps below zero.

// File: rtl/ctx_save_pkg.sv
package ctx_save_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WRITE = 2'd1,
      ST_DONE  = 2'd2
   } seq_state_e;

   localparam int FRAME_BYTES = 4;
   localparam int FRAME_W     = FRAME_BYTES * 8;

endpackage

// File: rtl/ctx_sp_select.sv
module ctx_sp_select #(
   parameter int SP_W  = 16,
   parameter int NUM_W = 8,
   parameter int SW_LO = 32,
   parameter int SW_HI = 63
) (
   input  logic             is_sw_int_i,
   input  logic [NUM_W-1:0] int_num_i,
   input  logic             user_flag_i,
   input  logic [SP_W-1:0]  isp_i,
   input  logic [SP_W-1:0]  usp_i,
   output logic [SP_W-1:0]  sp_o,
   output logic             use_user_o
);
   localparam logic [NUM_W-1:0] LO_V = NUM_W'(SW_LO);
   localparam logic [NUM_W-1:0] HI_V = NUM_W'(SW_HI);

   logic in_window;

   always_comb begin
      in_window  = is_sw_int_i && (int_num_i >= LO_V) && (int_num_i <= HI_V);
      use_user_o = in_window && user_flag_i;
      sp_o       = use_user_o ? usp_i : isp_i;
   end
endmodule

// File: rtl/ctx_frame_pack.sv
module ctx_frame_pack
   import ctx_save_pkg::*;
#(
   parameter int PC_W  = 20,
   parameter int FLG_W = 12
) (
   input  logic [PC_W-1:0]    pc_i,
   input  logic [FLG_W-1:0]   flags_i,
   output logic [FRAME_W-1:0] frame_o
);
   localparam int PC_HI_W  = PC_W - 16;
   localparam int FLG_HI_W = FLG_W - 8;

   logic [7:0] top_byte;

   generate
      if (PC_HI_W + FLG_HI_W == 8) begin : g_pack
         assign top_byte = {flags_i[FLG_W-1:8], pc_i[PC_W-1:16]};
      end else begin : g_bad
         assign top_byte = 8'h00;
         $error("ctx_frame_pack: high nibbles must fill exactly one byte");
      end
   endgenerate

   // byte 3 sits at SP-1, byte 0 at SP-4
   assign frame_o = {top_byte, flags_i[7:0], pc_i[15:8], pc_i[7:0]};
endmodule

// File: rtl/ctx_write_seq.sv
module ctx_write_seq
   import ctx_save_pkg::*;
#(
   parameter int SP_W           = 16,
   parameter bit LANE_REPLICATE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [SP_W-1:0]    sp_i,
   input  logic               use_user_i,
   input  logic [FRAME_W-1:0] frame_i,
   output logic [SP_W-1:0]    mem_addr_o,
   output logic [15:0]        mem_wdata_o,
   output logic [1:0]         mem_be_o,
   output logic               mem_we_o,
   input  logic               mem_ready_i,
   output logic               done_o,
   output logic [SP_W-1:0]    new_sp_o,
   output logic               sp_is_user_o
);
   seq_state_e         state_q;
   logic [1:0]         step_q;
   logic               odd_q;
   logic               user_q;
   logic [SP_W-1:0]    sp_q;
   logic [FRAME_W-1:0] frame_q;

   logic               last_step;
   logic [2:0]         offset;
   logic [7:0]         cur_byte;
   logic [15:0]        cur_word;
   logic               accept;

   always_comb begin
      last_step = odd_q ? (step_q == 2'd3) : (step_q == 2'd1);
      offset    = odd_q ? ({1'b0, step_q} + 3'd1) : (({1'b0, step_q} + 3'd1) << 1);
      cur_byte  = frame_q[8*(3 - step_q) +: 8];
      cur_word  = (step_q == 2'd0) ? frame_q[31:16] : frame_q[15:0];
      accept    = mem_we_o && mem_ready_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         step_q  <= 2'd0;
         odd_q   <= 1'b0;
         user_q  <= 1'b0;
         sp_q    <= '0;
         frame_q <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q <= ST_WRITE;
                  step_q  <= 2'd0;
                  odd_q   <= sp_i[0];
                  user_q  <= use_user_i;
                  sp_q    <= sp_i;
                  frame_q <= frame_i;
               end
            end
            ST_WRITE: begin
               if (mem_ready_i) begin
                  if (last_step) state_q <= ST_DONE;
                  else           step_q  <= step_q + 2'd1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_we_o     = (state_q == ST_WRITE);
   assign mem_addr_o   = sp_q - SP_W'(offset);
   assign done_o       = (state_q == ST_DONE);
   assign new_sp_o     = sp_q - SP_W'(4);
   assign sp_is_user_o = user_q;

   logic [15:0] byte_data;
   generate
      if (LANE_REPLICATE) begin : g_rep
         assign byte_data = {cur_byte, cur_byte};
      end else begin : g_lane
         assign byte_data = mem_addr_o[0] ? {cur_byte, 8'h00} : {8'h00, cur_byte};
      end
   endgenerate

   always_comb begin
      if (odd_q) begin
         mem_wdata_o = byte_data;
         mem_be_o    = mem_addr_o[0] ? 2'b10 : 2'b01;
      end else begin
         mem_wdata_o = cur_word;
         mem_be_o    = 2'b11;
      end
   end

   AST_EVEN_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_o && !odd_q) |-> (mem_be_o == 2'b11 && !mem_addr_o[0])); // R3
   AST_ODD_SINGLE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_o && odd_q) |-> ($countones(mem_be_o) == 1 && mem_be_o[1] == mem_addr_o[0])); // R4
   AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_o && !mem_ready_i) |=> (mem_we_o && $stable(mem_addr_o) && $stable(mem_wdata_o) && $stable(mem_be_o))); // R5
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R6
   AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> ($past(accept) && !mem_we_o)); // R6
   AST_NO_RESTART_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && start_i) |=> !mem_we_o); // R7
   AST_SP_DOWN_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && start_i) |=> (new_sp_o == $past(sp_i) - SP_W'(4))); // R6
endmodule

// File: rtl/ctx_save_seq.sv
module ctx_save_seq
   import ctx_save_pkg::*;
#(
   parameter int PC_W           = 20,
   parameter int FLG_W          = 12,
   parameter int SP_W           = 16,
   parameter int NUM_W          = 8,
   parameter int SW_LO          = 32,
   parameter int SW_HI          = 63,
   parameter bit LANE_REPLICATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             is_sw_int_i,
   input  logic [NUM_W-1:0] int_num_i,
   input  logic             user_stack_flag_i,
   input  logic [PC_W-1:0]  pc_i,
   input  logic [FLG_W-1:0] flags_i,
   input  logic [SP_W-1:0]  isp_i,
   input  logic [SP_W-1:0]  usp_i,
   output logic [SP_W-1:0]  mem_addr_o,
   output logic [15:0]      mem_wdata_o,
   output logic [1:0]       mem_be_o,
   output logic             mem_we_o,
   input  logic             mem_ready_i,
   output logic             done_o,
   output logic [SP_W-1:0]  new_sp_o,
   output logic             sp_is_user_o
);
   generate
      if (PC_W < 17 || PC_W > 24) begin : g_chk_pc
         $error("ctx_save_seq: PC_W must be 17..24");
      end
      if ((PC_W - 16) + (FLG_W - 8) != 8) begin : g_chk_nib
         $error("ctx_save_seq: PC and flag high parts must share one byte");
      end
      if (SP_W < 4) begin : g_chk_sp
         $error("ctx_save_seq: SP_W too small");
      end
      if (SW_LO > SW_HI || SW_HI >= (1 << NUM_W)) begin : g_chk_win
         $error("ctx_save_seq: bad software interrupt window");
      end
   endgenerate

   logic [SP_W-1:0]    sel_sp;
   logic               sel_user;
   logic [FRAME_W-1:0] frame;

   ctx_sp_select #(
      .SP_W (SP_W), .NUM_W (NUM_W), .SW_LO (SW_LO), .SW_HI (SW_HI)
   ) u_sel (
      .is_sw_int_i (is_sw_int_i),
      .int_num_i   (int_num_i),
      .user_flag_i (user_stack_flag_i),
      .isp_i       (isp_i),
      .usp_i       (usp_i),
      .sp_o        (sel_sp),
      .use_user_o  (sel_user)
   );

   ctx_frame_pack #(.PC_W (PC_W), .FLG_W (FLG_W)) u_pack (
      .pc_i    (pc_i),
      .flags_i (flags_i),
      .frame_o (frame)
   );

   ctx_write_seq #(.SP_W (SP_W), .LANE_REPLICATE (LANE_REPLICATE)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .sp_i         (sel_sp),
      .use_user_i   (sel_user),
      .frame_i      (frame),
      .mem_addr_o   (mem_addr_o),
      .mem_wdata_o  (mem_wdata_o),
      .mem_be_o     (mem_be_o),
      .mem_we_o     (mem_we_o),
      .mem_ready_i  (mem_ready_i),
      .done_o       (done_o),
      .new_sp_o     (new_sp_o),
      .sp_is_user_o (sp_is_user_o)
   );

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!mem_we_o && !done_o)); // R1
endmodule

// File: tb/tb_ctx_save_seq.sv
module tb_ctx_save_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        is_sw_int_i = 1'b0;
   logic [7:0]  int_num_i = '0;
   logic        user_stack_flag_i = 1'b0;
   logic [19:0] pc_i = '0;
   logic [11:0] flags_i = '0;
   logic [15:0] isp_i = '0;
   logic [15:0] usp_i = '0;
   logic [15:0] mem_addr_o;
   logic [15:0] mem_wdata_o;
   logic [1:0]  mem_be_o;
   logic        mem_we_o;
   logic        mem_ready_i = 1'b1;
   logic        done_o;
   logic [15:0] new_sp_o;
   logic        sp_is_user_o;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   ctx_save_seq dut (
      .clk (clk), .rst_n (rst_n), .start_i (start_i),
      .is_sw_int_i (is_sw_int_i), .int_num_i (int_num_i),
      .user_stack_flag_i (user_stack_flag_i), .pc_i (pc_i), .flags_i (flags_i),
      .isp_i (isp_i), .usp_i (usp_i), .mem_addr_o (mem_addr_o),
      .mem_wdata_o (mem_wdata_o), .mem_be_o (mem_be_o), .mem_we_o (mem_we_o),
      .mem_ready_i (mem_ready_i), .done_o (done_o), .new_sp_o (new_sp_o),
      .sp_is_user_o (sp_is_user_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // memory model and write log
   byte unsigned mem[int];
   logic [15:0] log_addr[8];
   logic [15:0] log_data[8];
   logic [1:0]  log_be[8];
   int nlog = 0;
   int ndone = 0;
   int stall_n = 0;
   int wait_cnt = 0;
   bit hold_pend = 0;
   logic [15:0] h_addr, h_data;
   logic [1:0]  h_be;

   always @(posedge clk) begin
      if (rst_n && mem_we_o && mem_ready_i) begin
         if (nlog < 8) begin
            log_addr[nlog] = mem_addr_o;
            log_data[nlog] = mem_wdata_o;
            log_be[nlog]   = mem_be_o;
         end
         nlog++;
         if (mem_be_o[0]) mem[int'({mem_addr_o[15:1], 1'b0})] = mem_wdata_o[7:0];
         if (mem_be_o[1]) mem[int'({mem_addr_o[15:1], 1'b1})] = mem_wdata_o[15:8];
      end
      if (rst_n && done_o) ndone++;
   end

   always @(negedge clk) begin
      if (hold_pend) begin
         // R5: held write unchanged while not ready
         chk(mem_we_o && mem_addr_o == h_addr && mem_wdata_o == h_data && mem_be_o == h_be,
             "R5", "held write", {mem_addr_o, mem_wdata_o}, {h_addr, h_data});
      end
      if (mem_we_o && wait_cnt < stall_n) begin
         mem_ready_i = 1'b0;
         wait_cnt++;
      end else begin
         mem_ready_i = 1'b1;
         wait_cnt = 0;
      end
      hold_pend = rst_n && mem_we_o && !mem_ready_i;
      h_addr = mem_addr_o;
      h_data = mem_wdata_o;
      h_be   = mem_be_o;
   end

   task automatic run_save(input logic [19:0] pc, input logic [11:0] flg,
                           input logic [15:0] isp, input logic [15:0] usp,
                           input bit sw, input logic [7:0] num, input bit u,
                           input int stall, input bit poke);
      logic [15:0] sp;
      logic [15:0] a;
      logic [7:0]  img[4];
      bit eu;
      int cyc;
      eu  = sw && num >= 8'd32 && num <= 8'd63 && u;
      sp  = eu ? usp : isp;
      img[0] = pc[7:0];  img[1] = pc[15:8];
      img[2] = flg[7:0]; img[3] = {flg[11:8], pc[19:16]};
      @(negedge clk);
      pc_i = pc; flags_i = flg; isp_i = isp; usp_i = usp;
      is_sw_int_i = sw; int_num_i = num; user_stack_flag_i = u;
      stall_n = stall; nlog = 0; ndone = 0;
      for (int k = 1; k <= 4; k++) mem[int'(sp - 16'(k))] = 8'hEE;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (poke) begin
         // R7: a second start mid-save with different context
         pc_i = ~pc; flags_i = ~flg; isp_i = isp + 16'h0100; usp_i = usp + 16'h0100;
         start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
      end
      cyc = 0;
      while (!done_o && cyc < 100) begin
         @(negedge clk);
         cyc++;
      end
      chk(done_o, "R6", "done seen", {31'b0, done_o}, 32'd1);
      chk(!mem_we_o, "R6", "strobe low at done", {31'b0, mem_we_o}, 32'd0);
      chk(new_sp_o == sp - 16'd4, "R6", "new sp", {16'b0, new_sp_o}, {16'b0, sp - 16'd4});
      chk(sp_is_user_o == eu, "R2", "pointer select", {31'b0, sp_is_user_o}, {31'b0, eu});
      @(negedge clk);
      chk(!done_o, "R6", "done one cycle", {31'b0, done_o}, 32'd0);
      repeat (8) @(negedge clk);
      chk(ndone == 1, "R7", "done count", ndone, 1);
      if (!sp[0]) begin
         chk(nlog == 2, "R3", "even write count", nlog, 2);
         chk(log_addr[0] == sp - 16'd2 && log_be[0] == 2'b11 && log_data[0] == {img[3], img[2]},
             "R3", "first word", {log_addr[0], log_data[0]}, {sp - 16'd2, img[3], img[2]});
         chk(log_addr[1] == sp - 16'd4 && log_be[1] == 2'b11 && log_data[1] == {img[1], img[0]},
             "R3", "second word", {log_addr[1], log_data[1]}, {sp - 16'd4, img[1], img[0]});
      end else begin
         chk(nlog == 4, "R4", "odd write count", nlog, 4);
         for (int k = 0; k < 4; k++) begin
            a = sp - 16'(k + 1);
            chk(log_addr[k] == a && log_be[k] == (a[0] ? 2'b10 : 2'b01) &&
                (a[0] ? log_data[k][15:8] : log_data[k][7:0]) == img[3-k],
                "R4", "byte write", {log_addr[k], 6'b0, log_be[k], (a[0] ? log_data[k][15:8] : log_data[k][7:0])},
                {a, 6'b0, (a[0] ? 2'b10 : 2'b01), img[3-k]});
         end
      end
      for (int k = 0; k < 4; k++) begin
         a = sp - 16'd4 + 16'(k);
         chk(mem[int'(a)] == img[k], "R8", "stack image byte", {16'b0, a[15:0]} ^ 32'h0 | {24'b0, mem[int'(a)]},
             {16'b0, a[15:0]} ^ 32'h0 | {24'b0, img[k]});
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: quiet in reset and just after
      chk(!mem_we_o && !done_o, "R1", "reset outputs", {30'b0, mem_we_o, done_o}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!mem_we_o && !done_o, "R1", "after reset", {30'b0, mem_we_o, done_o}, 32'd0);
      // hardware source, even ISP (R2 R3)
      run_save(20'hA5C3E, 12'h9B7, 16'h0400, 16'h0801, 1'b0, 8'd40, 1'b1, 0, 1'b0);
      // software 40, user flag set, odd USP (R2 R4)
      run_save(20'h12345, 12'h6AC, 16'h0400, 16'h0823, 1'b1, 8'd40, 1'b1, 0, 1'b0);
      // software 40, user flag clear, odd ISP with stalls (R2 R4 R5)
      run_save(20'hFEDCB, 12'h3F1, 16'h0A11, 16'h0800, 1'b1, 8'd40, 1'b0, 2, 1'b0);
      // software 10 below window uses ISP, even with stall (R2 R3 R5)
      run_save(20'h0F0F0, 12'h555, 16'h1200, 16'h3401, 1'b1, 8'd10, 1'b1, 1, 1'b0);
      // window edges 32 and 63 with user flag (R2)
      run_save(20'h80001, 12'h801, 16'h1200, 16'h2222, 1'b1, 8'd32, 1'b1, 0, 1'b0);
      run_save(20'h7FFFE, 12'h7FE, 16'h1200, 16'h2223, 1'b1, 8'd63, 1'b1, 0, 1'b0);
      // just outside window: 31 and 64 (R2)
      run_save(20'h11111, 12'h222, 16'h1300, 16'h2222, 1'b1, 8'd31, 1'b1, 0, 1'b0);
      run_save(20'h33333, 12'h444, 16'h1301, 16'h2222, 1'b1, 8'd64, 1'b1, 0, 1'b0);
      // start while busy is ignored (R7)
      run_save(20'hC0DE1, 12'hBEE, 16'h0501, 16'h0900, 1'b0, 8'd0, 1'b0, 2, 1'b1);
      run_save(20'h2468A, 12'h13A, 16'h0600, 16'h0900, 1'b0, 8'd0, 1'b0, 2, 1'b1);
      // wrap below zero, even and odd (R3 R4 R6)
      run_save(20'h9ABCD, 12'hE0F, 16'h0002, 16'h0900, 1'b0, 8'd0, 1'b0, 0, 1'b0);
      run_save(20'h54321, 12'h0F0, 16'h0001, 16'h0900, 1'b0, 8'd0, 1'b0, 1, 1'b0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule